// File: doc/BRIEF.md
# UART Receive Buffer with Flags

This block is the receive-side store of a UART. The deserializer pushes completed 11-bit words into it: eight data bits with three status bits above them. The topmost status bit marks a line break. The data-register read path pops words from the front of the store. Every pop copies the popped word's three status bits into a separate receive status register, which a status-register write clears again.

A mode input selects between a 16-deep circular buffer and a single-entry holding register. Any change of the mode input empties the store. The block drives empty and full flags and a ready signal back to the deserializer. It also drives a receive interrupt level that follows a programmable trigger count. All outputs except the front word are registered or come from registered state, so each push, pop or mode change is visible one cycle after the clock edge that takes it.

Top module: `uart_rxq`

## Requirements
- R1: After reset, `empty_o` is 1 and `full_o` is 0. `rx_irq_o` is 0, `sts_o` is 0, every stored word is zero (so `pop_word_o` is 0x000), the registered mode is "holding register", and `ready_o` is 1 while `fifo_en_i` is 0.
- R2: Words leave in the order they arrived. `pop_word_o` always shows the word at the read position. A pop with a nonzero count advances the read position modulo 16, and a push writes at read position plus count modulo 16.
- R3: `ready_o` is 1 only when `fifo_en_i` equals the registered mode and the count is below 16 (buffer mode, `fifo_en_i`=1) or below 1 (holding mode, `fifo_en_i`=0). A push while `ready_o` is 0 is dropped and stores nothing.
- R4: An accepted push sets `full_o` when the count becomes 16 in buffer mode, and on any accepted push in holding mode. A pop without an accepted push in the same cycle clears `full_o`, even when the store is empty.
- R5: `empty_o` is 1 exactly when the count is zero.
- R6: `brk_i` pushes the word 0x400: bit 10 set and data bits zero. This overrides `push_word_i` and `push_i`.
- R7: A pop loads bits [10:8] of the word at the read position into `sts_o`. A pop when empty leaves the count and read position unchanged and still loads the stale word's bits.
- R8: `sts_clr_i` clears `sts_o` on the next cycle, unless a pop in the same cycle loads it.
- R9: `rx_irq_o` rises when an accepted push makes the count equal `trig_i`. It falls when a pop makes the count equal `trig_i`-1. Otherwise it holds.
- R10: A cycle in which `fifo_en_i` differs from the registered mode takes the new mode. It sets count and read position to zero, clears `full_o` and `rx_irq_o`, and ignores push and pop in that cycle.
- R11: A push and a pop accepted in the same cycle with a nonzero count leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects 16-deep buffer, 0 selects single holding register |
| trig_i | input | 5 | Receive interrupt trigger count |
| push_i | input | 1 | Push `push_word_i` from the deserializer |
| brk_i | input | 1 | Push a break word (0x400) |
| push_word_i | input | 11 | Word to push: status [10:8], data [7:0] |
| pop_i | input | 1 | Data-register read: pop the front word |
| sts_clr_i | input | 1 | Status-register write: clear `sts_o` |
| pop_word_o | output | 11 | Word at the read position |
| sts_o | output | 3 | Receive status register |
| empty_o | output | 1 | Store holds no word |
| full_o | output | 1 | Full flag |
| ready_o | output | 1 | A push this cycle will be accepted |
| rx_irq_o | output | 1 | Receive interrupt level |

## Verification
A wrong count or read position shows at the ports on the very next cycle. `pop_word_o` then shows the wrong word, `empty_o` disagrees with the number of words pushed and popped, or `ready_o` stays high past the sixteenth word. A pointer fault that does not change the count stays hidden until the affected slot reaches the front, up to sixteen pops later. Filling the store across the wrap point and draining it exposes such faults. A missed flush on a mode change shows as soon as the front word is read: the read position must restart at slot zero.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned RXQ_DEPTH  = 16;
  localparam int unsigned RXQ_DATA_W = 8;
  localparam int unsigned RXQ_STS_W  = 3;

  // Break word: top status bit set, all data bits clear.
  function automatic logic [RXQ_DATA_W+RXQ_STS_W-1:0] brk_word();
    logic [RXQ_DATA_W+RXQ_STS_W-1:0] w;
    w = '0;
    w[RXQ_DATA_W+RXQ_STS_W-1] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 11,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wptr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  rptr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (we_i && wptr_i == PTR_W'(g))        mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[rptr_i];

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wptr_i)] == $past(wdata_i)) else $error("AST_WR_LANDS"); // R2
endmodule

// File: rtl/uart_rxq_sts.sv
module uart_rxq_sts #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STS_W  = 3,
  localparam int unsigned WORD_W = DATA_W + STS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [STS_W-1:0]  sts_o
);
  logic [STS_W-1:0] sts_q;

  // A pop outranks a clear in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= '0;
    else if (load_i) sts_q <= word_i[WORD_W-1:DATA_W];
    else if (clr_i)  sts_q <= '0;
  end

  assign sts_o = sts_q;

  AST_STS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i) |=> sts_o == '0) else $error("AST_STS_CLR"); // R8
  AST_STS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sts_o == $past(word_i[WORD_W-1:DATA_W])) else $error("AST_STS_LOAD"); // R7
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic             push_req_i,
  input  logic             pop_i,
  output logic             we_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic             pop_eff_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ready_o,
  output logic             irq_o
);
  logic             en_q, full_q, irq_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [PTR_W:0]   wsum;
  logic             flush, push_acc, pop_dec, irq_set, irq_clr;

  assign flush    = fifo_en_i != en_q;
  assign lim      = en_q ? CNT_W'(DEPTH) : CNT_W'(1);
  assign ready_o  = !flush && (cnt_q < lim);
  assign push_acc = push_req_i && ready_o;
  assign pop_eff_o = pop_i && !flush;
  assign pop_dec  = pop_eff_o && (cnt_q != '0);

  assign wsum   = {1'b0, rd_q} + (PTR_W+1)'(cnt_q);
  assign wptr_o = (wsum >= (PTR_W+1)'(DEPTH)) ? PTR_W'(wsum - (PTR_W+1)'(DEPTH)) : PTR_W'(wsum);
  assign we_o   = push_acc;
  assign rptr_o = rd_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push_acc) cnt_d = cnt_d + CNT_W'(1);
    if (pop_dec)  cnt_d = cnt_d - CNT_W'(1);
    rd_d = rd_q;
    if (pop_dec) rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
  end

  assign irq_set = push_acc && (cnt_d == trig_i);
  assign irq_clr = pop_eff_o && (cnt_d == trig_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (flush) begin
      en_q   <= fifo_en_i;
      cnt_q  <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      if (push_acc)   full_q <= !en_q || (cnt_d == CNT_W'(DEPTH));
      else if (pop_i) full_q <= 1'b0;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign empty_o = cnt_q == '0;
  assign full_o  = full_q;
  assign irq_o   = irq_q;

  AST_FULL_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> !ready_o) else $error("AST_FULL_NOT_READY"); // R3
  AST_DROP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_i && !ready_o && !pop_i && !flush) |=> $stable(cnt_q)) else $error("AST_DROP_HOLDS"); // R3
  AST_POP_CLR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_acc) |=> !full_q) else $error("AST_POP_CLR_FULL"); // R4
  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (cnt_q == '0 && rd_q == '0 && !full_q && !irq_q)) else $error("AST_FLUSH"); // R10
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_acc && pop_eff_o && cnt_q != '0) |=> $stable(cnt_q)) else $error("AST_BOTH_HOLD"); // R11
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim) else $error("AST_CNT_BOUND"); // R3
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = RXQ_DEPTH,
  parameter int unsigned DATA_W = RXQ_DATA_W,
  parameter int unsigned STS_W  = RXQ_STS_W,
  localparam int unsigned WORD_W = DATA_W + STS_W,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic [CNT_W-1:0]  trig_i,
  input  logic              push_i,
  input  logic              brk_i,
  input  logic [WORD_W-1:0] push_word_i,
  input  logic              pop_i,
  input  logic              sts_clr_i,
  output logic [WORD_W-1:0] pop_word_o,
  output logic [STS_W-1:0]  sts_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ready_o,
  output logic              rx_irq_o
);
  logic              we, pop_eff;
  logic [PTR_W-1:0]  wptr, rptr;
  logic [WORD_W-1:0] wdata, rdata;
  logic [WORD_W-1:0] brk_val;

  always_comb begin
    brk_val = '0;
    brk_val[WORD_W-1] = 1'b1;
  end

  assign wdata = brk_i ? brk_val : push_word_i;

  uart_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .trig_i     (trig_i),
    .push_req_i (push_i | brk_i),
    .pop_i      (pop_i),
    .we_o       (we),
    .wptr_o     (wptr),
    .rptr_o     (rptr),
    .pop_eff_o  (pop_eff),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .ready_o    (ready_o),
    .irq_o      (rx_irq_o)
  );

  uart_rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wptr_i  (wptr),
    .wdata_i (wdata),
    .rptr_i  (rptr),
    .rdata_o (rdata)
  );

  uart_rxq_sts #(.DATA_W(DATA_W), .STS_W(STS_W)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pop_eff),
    .clr_i  (sts_clr_i),
    .word_i (rdata),
    .sts_o  (sts_o)
  );

  assign pop_word_o = rdata;

  AST_BRK_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && ready_o && empty_o) |=> pop_word_o == brk_val) else $error("AST_BRK_WORD"); // R6
  AST_PUSH_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((push_i || brk_i) && ready_o && !pop_i) |=> !empty_o) else $error("AST_PUSH_NONEMPTY"); // R5
endmodule

// File: tb/sim_uart_rxq.sv
module sim_uart_rxq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b0;
  logic [4:0]  trig = 5'd1;
  logic        push = 1'b0, brk = 1'b0, pop = 1'b0, clr = 1'b0;
  logic [10:0] word = '0;
  logic [10:0] pop_word;
  logic [2:0]  sts;
  logic        empty, full, ready, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  uart_rxq u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .trig_i(trig),
    .push_i(push), .brk_i(brk), .push_word_i(word), .pop_i(pop),
    .sts_clr_i(clr), .pop_word_o(pop_word), .sts_o(sts), .empty_o(empty),
    .full_o(full), .ready_o(ready), .rx_irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic b, input logic q, input logic c, input logic [10:0] w);
    push = p; brk = b; pop = q; clr = c; word = w;
    @(posedge clk);
    @(negedge clk);
    push = 1'b0; brk = 1'b0; pop = 1'b0; clr = 1'b0; word = '0;
  endtask

  function automatic logic [10:0] fw(input int i);
    return {3'(i % 8), 8'(i * 17)};
  endfunction

  // {push, brk, pop, word[10:0], exp_empty, exp_full, exp_irq, exp_sts[2:0], exp_head[10:0]}
  localparam logic [30:0] VEC [8] = '{
    {1'b1,1'b0,1'b0,11'h041, 1'b0,1'b0,1'b1,3'd0,11'h041},
    {1'b1,1'b0,1'b0,11'h142, 1'b0,1'b0,1'b1,3'd0,11'h041},
    {1'b0,1'b0,1'b1,11'h000, 1'b0,1'b0,1'b1,3'd0,11'h142},
    {1'b1,1'b0,1'b1,11'h243, 1'b0,1'b0,1'b1,3'd1,11'h243},
    {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b0,1'b0,3'd2,11'h000},
    {1'b0,1'b1,1'b0,11'h0FF, 1'b0,1'b0,1'b1,3'd2,11'h400},
    {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b0,1'b0,3'd4,11'h000},
    {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b0,1'b0,3'd0,11'h000}
  };

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 ready", ready, 1);
    chk("R1 irq", irq, 0);
    chk("R1 sts", sts, 0);
    chk("R1 word", pop_word, 0);

    fifo_en = 1'b1;
    #1 chk("R10 ready low during mode change", ready, 0);
    cyc(0, 0, 0, 0, '0);
    chk("R3 ready in buffer mode", ready, 1);

    // R2 R4 R5 R6 R7 R9 R11 vector walk
    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][30], VEC[i][29], VEC[i][28], 1'b0, VEC[i][27:17]);
      chk($sformatf("R5 vec%0d empty", i), empty, VEC[i][16]);
      chk($sformatf("R4 vec%0d full", i), full, VEC[i][15]);
      chk($sformatf("R9 vec%0d irq", i), irq, VEC[i][14]);
      chk($sformatf("R7 vec%0d sts", i), sts, VEC[i][13:11]);
      chk($sformatf("R2 R6 R11 vec%0d head", i), pop_word, VEC[i][10:0]);
    end

    // R3 R4 R2: fill across wrap, drop, drain
    for (int i = 0; i < 16; i++) begin
      chk("R3 ready before fill push", ready, 1);
      cyc(1, 0, 0, 0, fw(i));
    end
    chk("R4 full at 16", full, 1);
    chk("R3 not ready at 16", ready, 0);
    cyc(1, 0, 0, 0, 11'h7FF);
    chk("R3 dropped push keeps full", full, 1);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R2 drain order %0d", i), pop_word, fw(i));
      cyc(0, 0, 1, 0, '0);
      if (i == 0) chk("R4 pop clears full", full, 0);
    end
    chk("R3 dropped word absent", empty, 1);
    chk("R7 last sts", sts, 7);
    chk("R9 irq falls at zero", irq, 0);

    // R10 R3 R4 holding mode
    fifo_en = 1'b0;
    cyc(0, 0, 0, 0, '0);
    chk("R10 read pos restarts at 0", pop_word, 11'h4CC);
    chk("R10 empty after change", empty, 1);
    cyc(1, 0, 0, 0, 11'h0C3);
    chk("R4 holding push sets full", full, 1);
    chk("R3 holding not ready", ready, 0);
    cyc(1, 0, 0, 0, 11'h0AA);
    chk("R3 holding drop", pop_word, 11'h0C3);
    cyc(0, 0, 1, 0, '0);
    chk("R4 holding pop clears full", full, 0);
    chk("R5 holding empty", empty, 1);
    cyc(0, 0, 1, 0, '0);
    chk("R7 empty pop keeps empty", empty, 1);

    // R10 flush with contents, push ignored in change cycle
    fifo_en = 1'b1;
    cyc(0, 0, 0, 0, '0);
    cyc(1, 0, 0, 0, 11'h111);
    cyc(1, 0, 0, 0, 11'h122);
    cyc(1, 0, 0, 0, 11'h133);
    chk("R9 irq before flush", irq, 1);
    fifo_en = 1'b0;
    cyc(1, 0, 0, 0, 11'h155);
    chk("R10 flush empty", empty, 1);
    chk("R10 flush irq", irq, 0);
    chk("R10 flush full", full, 0);
    fifo_en = 1'b1;
    cyc(0, 0, 0, 0, '0);
    chk("R10 second flush empty", empty, 1);

    // R9 trigger 4
    trig = 5'd4;
    cyc(1, 0, 0, 0, 11'h201);
    cyc(1, 0, 0, 0, 11'h202);
    cyc(1, 0, 0, 0, 11'h203);
    chk("R9 below trigger", irq, 0);
    cyc(1, 0, 0, 0, 11'h204);
    chk("R9 at trigger", irq, 1);
    cyc(0, 0, 1, 0, '0);
    chk("R9 pop to trigger-1", irq, 0);
    chk("R7 sts after pop", sts, 2);
    cyc(1, 0, 0, 0, 11'h305);
    chk("R9 re-arm", irq, 1);

    // R8 clear, and pop outranks clear
    cyc(0, 0, 0, 1, '0);
    chk("R8 clear", sts, 0);
    cyc(0, 0, 1, 1, '0);
    chk("R8 pop beats clear", sts, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule